// File: doc/BRIEF.md
# Channel Service Request Scheduler

This block picks which of a set of timer channels gets the single processing engine next. Each channel may raise a one-cycle service request at any time. The request is held until that channel is served. A host writes a two-bit level for every channel through a small register file. When the engine is free, the scheduler picks the pending channel with the highest level. If several channels share that level, the lowest channel number wins.

A granted thread owns the engine until the engine raises its end-of-thread input, or until the host sets a force-end control bit. While a thread runs, no other request can take the engine. At every thread start the scheduler gives a one-cycle start pulse and the granted channel number, so the engine can load that channel's context. Between threads the scheduler reports idle.

Top module: `chan_sched`

## Requirements
- R1: After reset the scheduler is idle, `thread_start_o` is low, `thread_ch_o` is 0, every channel level is 0, and every register reads 0.
- R2: Level registers sit at host addresses 0 and 1. Channel c uses bits [2(c mod 16)+1 : 2(c mod 16)] of word c/16. Writes take effect at the clock edge, and reads return the stored fields combinationally for the addressed word.
- R3: A request pulse on `chan_req_i[c]` stays pending until channel c is granted, and the grant clears it. A request that arrives while channel c is running, or in the same cycle as its grant, is kept and served later.
- R4: Level 0 disables a channel. A disabled channel is never granted, but its pending request is kept and is served once a non-zero level is written.
- R5: Among eligible pending channels, level 3 beats level 2 and level 2 beats level 1.
- R6: Among eligible pending channels at the same level, the lowest channel number wins.
- R7: Arbitration happens only in cycles where the scheduler is idle, and the grant is registered. In the following cycle `thread_start_o` is high for exactly one cycle, `thread_ch_o` shows the winner, and `sched_idle_o` is low.
- R8: While a thread runs, `thread_start_o` stays low and `thread_ch_o` stays constant until the thread ends, whatever requests arrive.
- R9: A host write to address 2 with bit 0 set ends the running thread at that edge, just as `eng_end_i` does. Address 2 always reads 0, and the write has no effect while idle.
- R10: A thread end makes `sched_idle_o` high in the next cycle, and the next grant can come one cycle later at the earliest. `eng_end_i` has no effect while idle.
- R11: A level write made in the same cycle as arbitration is not seen by that arbitration. A write made during a thread applies to the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req_i | input | 32 | Per-channel service request pulses |
| eng_end_i | input | 1 | Engine end-of-thread |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data for `host_addr_i` |
| thread_start_o | output | 1 | One-cycle pulse at thread start |
| thread_ch_o | output | 5 | Channel owning the current or last thread |
| sched_idle_o | output | 1 | No thread running |

## Verification
The bench sends a higher-level request while a thread runs. A preemptive design would pulse start or change the channel mid-thread. It also raises ties at a common level, which a design that scans from the top channel down would resolve wrongly. It parks a request on a disabled channel and then enables it: a design that drops disabled requests never serves it, and one that ignores the level grants it at once. It also re-requests a channel during its own service, force-ends threads while running and while idle, and changes levels during a thread. A behavioural model checked every cycle catches any off-by-one in the end-to-idle-to-grant timing, or a level write seen one cycle early.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int PRIO_W    = 2;
    localparam int NUM_LVL   = 1 << PRIO_W;
    localparam int FORCE_BIT = 0;

    typedef enum logic [PRIO_W-1:0] {
        LVL_OFF  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_HIGH = 2'd3
    } lvl_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_st_e;

    function automatic logic lvl_enabled(input logic [PRIO_W-1:0] l);
        return l != LVL_OFF;
    endfunction

endpackage

// File: rtl/sched_host_regs.sv
module sched_host_regs
    import sched_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_CH*PRIO_W-1:0]   lvl_flat,
    output logic                       force_end
);
    localparam int CPW       = DATA_W / PRIO_W;
    localparam int NUM_WORDS = (NUM_CH + CPW - 1) / CPW;
    localparam int CTRL_ADDR = NUM_WORDS;

    logic [PRIO_W-1:0] lvl_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
        localparam int WIDX = c / CPW;
        localparam int FOFS = (c % CPW) * PRIO_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[c] <= LVL_OFF;
            end else if (we && addr == ADDR_W'(WIDX)) begin
                lvl_q[c] <= wdata[FOFS +: PRIO_W];
            end
        end
        assign lvl_flat[c*PRIO_W +: PRIO_W] = lvl_q[c];
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(c / CPW)) begin
                rdata[(c % CPW)*PRIO_W +: PRIO_W] = lvl_q[c];
            end
        end
    end

    assign force_end = we && (addr == ADDR_W'(CTRL_ADDR)) && wdata[FORCE_BIT];

endmodule

// File: rtl/sched_req_latch.sv
module sched_req_latch #(
    parameter int NUM_CH = 32,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    input  logic              clr_en,
    input  logic [CH_W-1:0]   clr_ch,
    output logic [NUM_CH-1:0] pend
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
        logic hit;
        assign hit = clr_en && (clr_ch == CH_W'(c));
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[c] <= 1'b0;
            end else begin
                pend[c] <= (pend[c] && !hit) || req[c];
            end
        end
    end
endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter
    import sched_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CH_W   = 5
) (
    input  logic [NUM_CH-1:0]        pend,
    input  logic [NUM_CH*PRIO_W-1:0] lvl_flat,
    output logic                     win_valid,
    output logic [CH_W-1:0]          win_ch
);
    logic [NUM_LVL-1:0][NUM_CH-1:0] hit;
    logic [NUM_CH-1:0]              sel;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            if (l == 0) begin : g_off
                assign hit[l][c] = 1'b0;
            end else begin : g_on
                assign hit[l][c] = pend[c] &&
                    (lvl_flat[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
            end
        end
    end

    always_comb begin
        sel       = '0;
        win_valid = 1'b0;
        for (int l = NUM_LVL - 1; l >= 1; l--) begin
            if (!win_valid && |hit[l]) begin
                sel       = hit[l];
                win_valid = 1'b1;
            end
        end
        win_ch = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (sel[c]) win_ch = CH_W'(c);
        end
    end
endmodule

// File: rtl/chan_sched.sv
module chan_sched
    import sched_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int DATA_W = 32,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int CPW       = DATA_W / PRIO_W,
    localparam int NUM_WORDS = (NUM_CH + CPW - 1) / CPW,
    localparam int ADDR_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_req_i,
    input  logic              eng_end_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              thread_start_o,
    output logic [CH_W-1:0]   thread_ch_o,
    output logic              sched_idle_o
);
    sched_st_e                st_q;
    logic [CH_W-1:0]          ch_q;
    logic                     start_q;
    logic [NUM_CH-1:0]        pend;
    logic [NUM_CH*PRIO_W-1:0] lvl_flat;
    logic                     force_end;
    logic                     win_valid;
    logic [CH_W-1:0]          win_ch;
    logic                     fire;

    sched_host_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .we(host_we_i), .addr(host_addr_i),
        .wdata(host_wdata_i), .rdata(host_rdata_o),
        .lvl_flat(lvl_flat), .force_end(force_end)
    );

    sched_req_latch #(.NUM_CH(NUM_CH), .CH_W(CH_W)) latch_i (
        .clk(clk), .rst(rst), .req(chan_req_i),
        .clr_en(fire), .clr_ch(win_ch), .pend(pend)
    );

    sched_arbiter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) arb_i (
        .pend(pend), .lvl_flat(lvl_flat),
        .win_valid(win_valid), .win_ch(win_ch)
    );

    assign fire = (st_q == ST_IDLE) && win_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ch_q    <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (st_q)
                ST_RUN: begin
                    if (eng_end_i || force_end) st_q <= ST_IDLE;
                end
                default: begin
                    if (fire) begin
                        st_q    <= ST_RUN;
                        ch_q    <= win_ch;
                        start_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign thread_start_o = start_q;
    assign thread_ch_o    = ch_q;
    assign sched_idle_o   = (st_q == ST_IDLE);

endmodule

// File: rtl/chan_sched_chk.sv
module chan_sched_chk
    import sched_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CH_W   = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     idle,
    input logic [CH_W-1:0]          ch,
    input logic                     eng_end,
    input logic                     force_end,
    input logic                     win_valid,
    input logic [NUM_CH-1:0]        pend,
    input logic [NUM_CH*PRIO_W-1:0] lvl_flat
);
    logic [NUM_CH-1:0]        pend_prev;
    logic [NUM_CH*PRIO_W-1:0] lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_prev <= '0;
            lvl_prev  <= '0;
        end else begin
            pend_prev <= pend;
            lvl_prev  <= lvl_flat;
        end
    end

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !idle);

    // R8
    thread_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && !eng_end && !force_end) |=> (!idle && !start && $stable(ch)));

    // R9
    thread_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && (eng_end || force_end)) |=> idle);

    // R10
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !win_valid) |=> (idle && !start));

    // R3
    grant_pending_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> pend_prev[ch]);

    // R4
    grant_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> lvl_enabled(lvl_prev[int'(ch)*PRIO_W +: PRIO_W]));

endmodule

bind chan_sched chan_sched_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
    .clk(clk), .rst(rst), .start(thread_start_o), .idle(sched_idle_o),
    .ch(thread_ch_o), .eng_end(eng_end_i), .force_end(force_end),
    .win_valid(win_valid), .pend(pend), .lvl_flat(lvl_flat)
);

// File: tb/chan_sched_tb_top.sv
module chan_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] chan_req_i = '0;
    logic        eng_end_i = 1'b0;
    logic        host_we_i = 1'b0;
    logic [1:0]  host_addr_i = '0;
    logic [31:0] host_wdata_i = '0;
    logic [31:0] host_rdata_o;
    logic        thread_start_o;
    logic [4:0]  thread_ch_o;
    logic        sched_idle_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chan_sched dut_i (
        .clk(clk), .rst(rst), .chan_req_i(chan_req_i), .eng_end_i(eng_end_i),
        .host_we_i(host_we_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o), .thread_start_o(thread_start_o),
        .thread_ch_o(thread_ch_o), .sched_idle_o(sched_idle_o)
    );

    // behavioural reference model
    bit m_pend [32];
    int m_lvl  [32];
    bit m_busy;
    bit m_start;
    int m_ch;
    int best;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 32; c++) begin m_pend[c] = 0; m_lvl[c] = 0; end
            m_busy = 0; m_start = 0; m_ch = 0;
        end else begin
            m_start = 0;
            if (m_busy) begin
                if (eng_end_i || (host_we_i && host_addr_i == 2 && host_wdata_i[0]))
                    m_busy = 0;
            end else begin
                best = -1;
                for (int l = 3; l >= 1; l--)
                    for (int c = 0; c < 32; c++)
                        if (best < 0 && m_pend[c] && m_lvl[c] == l) best = c;
                if (best >= 0) begin
                    m_busy = 1; m_start = 1; m_ch = best; m_pend[best] = 0;
                end
            end
            for (int c = 0; c < 32; c++) if (chan_req_i[c]) m_pend[c] = 1;
            if (host_we_i && host_addr_i < 2)
                for (int k = 0; k < 16; k++)
                    m_lvl[host_addr_i*16 + k] = int'(host_wdata_i[2*k +: 2]);
        end
    end

    function automatic logic [31:0] model_rdata(input logic [1:0] a);
        logic [31:0] w = '0;
        if (a < 2) for (int k = 0; k < 16; k++) w[2*k +: 2] = 2'(m_lvl[a*16 + k]);
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(sched_idle_o == !m_busy, "R7 R10 idle vs model", 32'(sched_idle_o), 32'(!m_busy));
            chk(thread_start_o == m_start, "R7 R8 start vs model", 32'(thread_start_o), 32'(m_start));
            chk(int'(thread_ch_o) == m_ch, "R5 R6 channel vs model", 32'(thread_ch_o), 32'(m_ch));
            chk(host_rdata_o == model_rdata(host_addr_i), "R2 R11 readback vs model",
                host_rdata_o, model_rdata(host_addr_i));
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic pulse_req(input logic [31:0] m);
        chan_req_i = m; tick(); chan_req_i = '0;
    endtask

    task automatic pulse_end();
        eng_end_i = 1; tick(); eng_end_i = 0;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        host_we_i = 1; host_addr_i = a; host_wdata_i = d; tick();
        host_we_i = 0; host_wdata_i = '0;
    endtask

    task automatic expect_start(input int exp_ch, input string tag);
        bit got = 0;
        for (int i = 0; i < 10 && !got; i++) begin
            tick();
            if (thread_start_o) got = 1;
        end
        chk(got && int'(thread_ch_o) == exp_ch, tag, 32'(thread_ch_o), 32'(exp_ch));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(sched_idle_o == 1, "R1 idle after reset", 32'(sched_idle_o), 1);
        chk(thread_start_o == 0, "R1 start after reset", 32'(thread_start_o), 0);
        chk(thread_ch_o == 0, "R1 channel after reset", 32'(thread_ch_o), 0);
        chk(host_rdata_o == 0, "R1 word0 after reset", host_rdata_o, 0);
        host_addr_i = 2; tick();
        chk(host_rdata_o == 0, "R1 ctrl after reset", host_rdata_o, 0);

        // R2 level registers
        host_write(0, 32'h5555_5555);
        host_write(1, 32'h5555_555D);
        host_addr_i = 0; tick();
        chk(host_rdata_o == 32'h5555_5555, "R2 word0 readback", host_rdata_o, 32'h5555_5555);
        host_addr_i = 1; tick();
        chk(host_rdata_o == 32'h5555_555D, "R2 word1 channel17 field", host_rdata_o, 32'h5555_555D);

        // R6 tie at level 1
        pulse_req((32'd1 << 9) | (32'd1 << 4) | (32'd1 << 20));
        expect_start(4, "R6 lowest channel wins tie");
        // R8 no preemption by level-3 channel 17
        pulse_req(32'd1 << 17);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!thread_start_o && thread_ch_o == 4 && !sched_idle_o, "R8 thread held",
                32'(thread_ch_o), 4);
        end
        pulse_end();
        chk(sched_idle_o == 1, "R10 idle after end", 32'(sched_idle_o), 1);
        expect_start(17, "R5 higher level wins");
        pulse_end();
        expect_start(9, "R6 next lowest at level 1");

        // R9 force end
        host_write(2, 32'h1);
        chk(sched_idle_o == 1, "R9 force end stops thread", 32'(sched_idle_o), 1);
        expect_start(20, "R9 next grant after force end");
        host_addr_i = 2; tick();
        chk(host_rdata_o == 0, "R9 ctrl reads zero", host_rdata_o, 0);
        pulse_end();

        // R10 end while idle ignored
        for (int i = 0; i < 4; i++) begin
            pulse_end();
            chk(sched_idle_o && !thread_start_o, "R10 end while idle", 32'(sched_idle_o), 1);
        end
        host_write(2, 32'h1);
        chk(sched_idle_o && !thread_start_o, "R9 force while idle", 32'(sched_idle_o), 1);

        // R4 disabled channel keeps pending request
        host_write(0, 32'h5555_5155);
        pulse_req(32'd1 << 5);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(sched_idle_o && !thread_start_o, "R4 disabled not granted", 32'(sched_idle_o), 1);
        end
        host_write(0, 32'h5555_5955);
        expect_start(5, "R4 pending served after enable");

        // R3 re-request during own service
        pulse_req(32'd1 << 5);
        pulse_end();
        expect_start(5, "R3 request during service kept");

        // R11 level change during a thread
        pulse_req((32'd1 << 2) | (32'd1 << 30));
        host_write(1, 32'h7555_555D);
        pulse_end();
        expect_start(30, "R11 new level used at next arbitration");
        pulse_end();
        expect_start(2, "R11 remaining request");
        pulse_end();

        // mixed traffic against the model
        r = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            chan_req_i = r & (r >> 3) & (r << 7);
            eng_end_i  = (r[6:4] == 3'd0);
            if (r[15:10] == 6'd0) begin
                host_we_i = 1; host_addr_i = 2'(r[17:16] % 3);
                host_wdata_i = r ^ (r >> 11);
            end else begin
                host_we_i = 0; host_addr_i = 2'(r[19:18] % 3); host_wdata_i = '0;
            end
            tick();
        end
        chan_req_i = '0; eng_end_i = 0; host_we_i = 0;
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule